// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block gathers interrupt requests from a set of peripheral sources and offers at most one of them at a time to a CPU core. Software sets, for each maskable source, an enable bit and a one-bit level: high priority or no priority. A lower source index breaks ties between requests on the same level. A global mask bit from the CPU holds back every maskable source. Two special inputs ignore that mask and the level settings: a non-maskable interrupt and an address-break event.

The CPU sees a request-valid line and a vector number. The vector stays put until the CPU pulses acknowledge, which it does when it takes the request at an instruction boundary. On acknowledge, the pending flag of an edge-type source or of the non-maskable input is cleared. A level-type source stays pending for as long as its line is high. Each source is edge-type or level-type according to a parameter. Saving state on the stack and fetching the vector are the CPU's job.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all enable bits and level bits are 0 and `irqReq` is 0. With the reset settings, asserted source lines produce no request.
- R2: A maskable source i is presented only while `enReg[i]` is 1. A configuration write (`cfgWe`=1) loads `cfgData` into the enable register when `cfgSel`=0 and into the level register when `cfgSel`=1.
- R3: While `cpuMask` is 1, no maskable source is presented. The address-break line (vector 1) and the non-maskable input (vector 0) are still presented.
- R4: While `cpuMask` is 0, any enabled pending source can be presented.
- R5: A pending source whose level bit is 1 is presented before any pending source whose level bit is 0. The level-0 source stays pending and is presented later.
- R6: When several sources on the same level are pending, the one with the lowest index wins. The others stay pending.
- R7: The order of priority is: non-maskable first, then address break, then level-1 sources, then level-0 sources. The vector for source i is i+2. The non-maskable input reacts to rising edges only, so one edge gives exactly one presentation.
- R8: While `irqReq` is 1 and no acknowledge arrives, `irqVec` and `irqReq` do not change. An acknowledge clears the pending flag of the edge-type source it serves. That flag is set by a rising edge of the source's line.
- R9: A level-type source is still pending after acknowledge as long as its line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects the enable register, 1 selects the level register |
| cfgData | input | NUM_SRC | Write data, one bit per source |
| srcReq | input | NUM_SRC | Request lines of the maskable sources |
| nmiIn | input | 1 | Non-maskable interrupt input, rising-edge sensitive |
| abrkIn | input | 1 | Address-break request, level sensitive |
| cpuMask | input | 1 | CPU global mask bit |
| irqAck | input | 1 | CPU acknowledge pulse |
| irqReq | output | 1 | Request valid to the CPU |
| irqVec | output | VEC_W | Vector number of the presented request |

## Verification
The bench uses the defaults: eight sources, with sources 0 to 3 edge-type and sources 4 to 7 level-type. This lets one run compare edge flags that clear on acknowledge with level lines that come back. With eight sources, two sources can be placed on each level at once, so the bench can order them across levels and within one level. Raising the non-maskable input and an edge source together, with the address break arriving while the non-maskable vector is held, exercises the full priority chain and the hold-until-acknowledge rule.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_NMI  = 0;
  localparam int VEC_ABRK = 1;
  localparam int VEC_BASE = 2;

  typedef struct packed {
    logic load;
    logic retire;
  } irqStrobe_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC-1:0] EDGE_SRC = '0,
  parameter int VEC_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgWe,
  input  logic               cfgSel,
  input  logic [NUM_SRC-1:0] cfgData,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               nmiIn,
  input  irqStrobe_t         stb,
  input  logic [VEC_W-1:0]   winVec,
  output logic               nmiPend,
  output logic [NUM_SRC-1:0] eligHi,
  output logic [NUM_SRC-1:0] eligLo,
  output logic               holdValid,
  output logic [VEC_W-1:0]   holdVec
);
  logic [NUM_SRC-1:0] enReg, lvReg, srcPrev, edgePend, pendEff, retireHit;
  logic nmiPrev;
  logic nmiRise;

  assign nmiRise = nmiIn && !nmiPrev;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      retireHit[i] = stb.retire && (holdVec == VEC_W'(VEC_BASE + i));
  end

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
      if (EDGE_SRC[g]) begin : gEdge
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) edgePend[g] <= 1'b0;
          else if (srcReq[g] && !srcPrev[g]) edgePend[g] <= 1'b1;
          else if (retireHit[g]) edgePend[g] <= 1'b0;
        assign pendEff[g] = edgePend[g];
      end else begin : gLevel
        assign edgePend[g] = 1'b0;
        assign pendEff[g]  = srcReq[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enReg     <= '0;
      lvReg     <= '0;
      srcPrev   <= '0;
      nmiPrev   <= 1'b0;
      nmiPend   <= 1'b0;
      holdValid <= 1'b0;
      holdVec   <= '0;
    end else begin
      srcPrev <= srcReq;
      nmiPrev <= nmiIn;
      if (cfgWe && !cfgSel) enReg <= cfgData;
      if (cfgWe && cfgSel)  lvReg <= cfgData;
      if (nmiRise) nmiPend <= 1'b1;
      else if (stb.retire && holdVec == VEC_W'(VEC_NMI)) nmiPend <= 1'b0;
      if (stb.retire) holdValid <= 1'b0;
      else if (stb.load) begin
        holdValid <= 1'b1;
        holdVec   <= winVec;
      end
    end
  end

  assign eligHi = pendEff & enReg & lvReg;
  assign eligLo = pendEff & enReg & ~lvReg;

  logic [VEC_W-1:0] winIdx;
  assign winIdx = winVec - VEC_W'(VEC_BASE);

  p_enable_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load && winVec >= VEC_W'(VEC_BASE) |-> enReg[winIdx]);

  p_nmi_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.retire && holdVec == VEC_W'(VEC_NMI) && !nmiRise |=> !nmiPend);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmiPend,
  input  logic               abrkIn,
  input  logic               cpuMask,
  input  logic [NUM_SRC-1:0] eligHi,
  input  logic [NUM_SRC-1:0] eligLo,
  input  logic               holdValid,
  input  logic               irqAck,
  output irqStrobe_t         stb,
  output logic [VEC_W-1:0]   winVec
);
  logic anyWin;
  logic hiFound, loFound;
  logic [VEC_W-1:0] hiVec, loVec;

  always_comb begin
    hiFound = 1'b0;
    loFound = 1'b0;
    hiVec   = '0;
    loVec   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligHi[i]) begin
        hiFound = 1'b1;
        hiVec   = VEC_W'(VEC_BASE + i);
      end
      if (eligLo[i]) begin
        loFound = 1'b1;
        loVec   = VEC_W'(VEC_BASE + i);
      end
    end
  end

  always_comb begin
    anyWin = 1'b1;
    winVec = '0;
    if (nmiPend)                 winVec = VEC_W'(VEC_NMI);
    else if (abrkIn)             winVec = VEC_W'(VEC_ABRK);
    else if (!cpuMask && hiFound) winVec = hiVec;
    else if (!cpuMask && loFound) winVec = loVec;
    else                         anyWin = 1'b0;
  end

  assign stb.load   = anyWin && !holdValid;
  assign stb.retire = holdValid && irqAck;

  p_nmi_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load && nmiPend |-> winVec == VEC_W'(VEC_NMI));

  p_level_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load && !nmiPend && !abrkIn && !cpuMask && (|eligHi)
      |-> eligHi[winVec - VEC_W'(VEC_BASE)]);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC-1:0] EDGE_SRC = 8'h0F,
  localparam int VEC_W = $clog2(NUM_SRC + VEC_BASE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgWe,
  input  logic               cfgSel,
  input  logic [NUM_SRC-1:0] cfgData,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               nmiIn,
  input  logic               abrkIn,
  input  logic               cpuMask,
  input  logic               irqAck,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVec
);
  irqStrobe_t stb;
  logic [VEC_W-1:0] winVec;
  logic nmiPend;
  logic [NUM_SRC-1:0] eligHi, eligLo;

  irq_datapath #(.NUM_SRC(NUM_SRC), .EDGE_SRC(EDGE_SRC), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .srcReq(srcReq), .nmiIn(nmiIn), .stb(stb), .winVec(winVec),
    .nmiPend(nmiPend), .eligHi(eligHi), .eligLo(eligLo),
    .holdValid(irqReq), .holdVec(irqVec)
  );

  irq_ctrl #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .nmiPend(nmiPend), .abrkIn(abrkIn), .cpuMask(cpuMask),
    .eligHi(eligHi), .eligLo(eligLo), .holdValid(irqReq), .irqAck(irqAck),
    .stb(stb), .winVec(winVec)
  );

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqReq) && $past(cpuMask) |-> irqVec < VEC_W'(VEC_BASE));

  p_vec_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq && !irqAck |=> irqReq && $stable(irqVec));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int N = 8;
  localparam int VW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic cfgWe = 0, cfgSel = 0;
  logic [N-1:0] cfgData = '0;
  logic [N-1:0] srcReq = '0;
  logic nmiIn = 0, abrkIn = 0, cpuMask = 0, irqAck = 0;
  logic irqReq;
  logic [VW-1:0] irqVec;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(N), .EDGE_SRC(8'h0F)) u0 (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .srcReq(srcReq), .nmiIn(nmiIn), .abrkIn(abrkIn), .cpuMask(cpuMask),
    .irqAck(irqAck), .irqReq(irqReq), .irqVec(irqVec)
  );

  task automatic waitCyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic expReq, input logic [VW-1:0] expVec);
    total++;
    if (irqReq !== expReq || (expReq && irqVec !== expVec)) begin
      bad++;
      $display("FAIL %s: got req=%0b vec=%0d, expected req=%0b vec=%0d",
               tag, irqReq, irqVec, expReq, expVec);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [N-1:0] d);
    @(negedge clk);
    cfgWe = 1; cfgSel = sel; cfgData = d;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic ack();
    @(negedge clk);
    irqAck = 1;
    @(negedge clk);
    irqAck = 0;
    waitCyc(3);
  endtask

  task automatic testReset();
    waitCyc(1);
    chk("R1 reset", 0, 0);
    srcReq = 8'hF0;
    waitCyc(4);
    chk("R1 disabled at reset", 0, 0);
    srcReq = '0;
    waitCyc(2);
  endtask

  task automatic testEnable();
    cfgWrite(0, 8'h10);
    srcReq = 8'h30;
    waitCyc(3);
    chk("R2 enabled source 4", 1, 6);
    ack();
    chk("R9 level source re-presented", 1, 6);
    srcReq = 8'h20;
    ack();
    chk("R2 disabled source 5 ignored", 0, 0);
    srcReq = '0;
  endtask

  task automatic testMask();
    cfgWrite(0, 8'hFF);
    cpuMask = 1;
    srcReq = 8'h10;
    waitCyc(4);
    chk("R3 masked source held", 0, 0);
    abrkIn = 1;
    waitCyc(3);
    chk("R3 address break bypasses mask", 1, 1);
    abrkIn = 0;
    ack();
    chk("R3 still masked after break", 0, 0);
    cpuMask = 0;
    waitCyc(3);
    chk("R4 unmasked source accepted", 1, 6);
    srcReq = '0;
    ack();
  endtask

  task automatic testLevels();
    cfgWrite(1, 8'h40);
    srcReq = 8'h60;
    waitCyc(3);
    chk("R5 level-1 source first", 1, 8);
    srcReq = 8'h20;
    ack();
    chk("R5 level-0 source kept pending", 1, 7);
    srcReq = '0;
    ack();
    cfgWrite(1, 8'h00);
  endtask

  task automatic testOrder();
    srcReq = 8'h90;
    waitCyc(3);
    chk("R6 lower index wins", 1, 6);
    srcReq = 8'h80;
    ack();
    chk("R6 other kept pending", 1, 9);
    srcReq = '0;
    ack();
    chk("R6 idle", 0, 0);
  endtask

  task automatic testNmiEdge();
    @(negedge clk);
    nmiIn = 1; srcReq = 8'h02;
    @(negedge clk);
    srcReq = '0;
    waitCyc(3);
    chk("R7 nmi first", 1, 0);
    abrkIn = 1;
    waitCyc(3);
    chk("R8 vector held until ack", 1, 0);
    abrkIn = 0;
    waitCyc(1);
    ack();
    chk("R7 nmi edge once, then edge source", 1, 3);
    ack();
    chk("R8 ack clears edge pending", 0, 0);
    nmiIn = 0;
    waitCyc(2);
  endtask

  initial begin
    waitCyc(3);
    rst_n = 1;
    testReset();
    testEnable();
    testMask();
    testLevels();
    testOrder();
    testNmiEdge();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule